// File: doc/BRIEF.md
# Automatic Serial Gamepad Reader

This block collects the button state of two serial controller ports once per frame. Each port has two data lines, and one latch line is shared by both ports. When a start-of-vertical-blank pulse arrives and the enable bit is set, the block raises the latch for one phase and then drops it for one phase. It then gives both port clocks sixteen low/high pulses together. Near the end of each low phase it samples all four data lines and shifts the four bits into four 16-bit shift registers. When the sixteenth pulse ends, the four words are copied into result registers, and the busy flag clears.

Software reaches the block through a byte-wide register interface with a 4-bit address. Address 0 holds the enable bit in bit 0 and can be read and written. Address 1 returns the busy flag in bit 0. Address 2 is the manual port-1 register: a write sets the shared latch from bit 0, and a read returns data line 1 in bit 0 and data line 2 in bit 1. Address 3 gives the same read view of port 2. When the block is idle, a manual read pulses that port's clock low for one cycle after the sample. The result words sit at address 8+2k for the low byte and 9+2k for the high byte. Word k=0 is port 1 line 1, k=1 is port 2 line 1, k=2 is port 1 line 2 and k=3 is port 2 line 2.

Each phase lasts PHASE_CYC system clocks, so one read spans 34 phases. The default is sized to roughly three video lines.

Top module: `padpoll_top`

## Requirements
- R1: After reset, the enable bit (address 0, bit 0) reads 0, the busy bit (address 1, bit 0) reads 0, all eight result bytes (addresses 8 to 15) read 0, the latch is low and both port clocks are high.
- R2: A read sequence starts only on a clock edge where vbStart is 1 and the enable bit is 1 while the block is idle. A vbStart pulse with the enable bit at 0, or a pulse while a read is in progress, starts nothing and does not restart the read.
- R3: A sequence drives the latch high for PHASE_CYC cycles and then low for PHASE_CYC cycles. It then drives both port clocks low for PHASE_CYC cycles and high for PHASE_CYC cycles, together, sixteen times. The latch is never high while a clock is low. Busy reads 1 for exactly 34*PHASE_CYC consecutive cycles, starting the cycle after the start edge.
- R4: The data lines are sampled at the last cycle of each clock-low phase. The first bit sampled ends up in bit 15 of its word and the sixteenth in bit 0. The words are mapped as k=0 port 1 line 1 (pad1Data[0]), k=1 port 2 line 1 (pad2Data[0]), k=2 port 1 line 2 (pad1Data[1]) and k=3 port 2 line 2 (pad2Data[1]).
- R5: Word k is read from address 8+2k for bits 7:0 and from address 9+2k for bits 15:8. rdData is combinational from addr.
- R6: Writing address 0 sets the enable bit from wrData[0], and reading address 0 returns it in bit 0. Address 1 returns busy in bit 0. All other bits of both registers read 0.
- R7: Writing address 2 while idle drives the shared latch from wrData[0] from the next cycle on. Such a write is ignored while busy is 1, and the latch returns to the previously written manual value when the read ends.
- R8: Reading address 2 returns {6'b0, pad1Data[1], pad1Data[0]}, and reading address 3 returns {6'b0, pad2Data[1], pad2Data[0]}. When the block is idle, such a read drives that port's clock low for the one cycle after the read cycle. While busy, a read does not touch the clocks.
- R9: The result registers keep their previous values until a sequence completes, including for the whole time it is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| vbStart | input | 1 | One-cycle start-of-vertical-blank pulse |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (side effects only) |
| addr | input | 4 | Register address |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data, combinational from addr |
| padLatch | output | 1 | Shared latch line for both ports |
| pad1Clk | output | 1 | Port 1 clock, idle high |
| pad2Clk | output | 1 | Port 2 clock, idle high |
| pad1Data | input | 2 | Port 1 data lines, bit 0 = line 1 |
| pad2Data | input | 2 | Port 2 data lines, bit 0 = line 1 |

## Verification
The checks on the clock pairing and on the latch never overlapping a low clock apply only while a read is in progress. In idle time the bench pulses one port's clock by hand, which separates the two clocks, and it never does so while holding the manual latch high. The check that the results hold steady assumes that only a finished read updates them. The bench keeps vbStart to single-cycle pulses, and it reads back results only through the address map, so its pad model sees nothing but the latch and clock pins.

// File: rtl/padpoll_pkg.sv
package padpoll_pkg;
  localparam int LINE_BITS = 16;
  localparam int NUM_WORDS = 4;
  localparam int ADDR_W    = 4;
  localparam int DATA_W    = 8;

  localparam logic [ADDR_W-1:0] REG_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] REG_STATUS = 4'd1;
  localparam logic [ADDR_W-1:0] REG_PORT1  = 4'd2;
  localparam logic [ADDR_W-1:0] REG_PORT2  = 4'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LATCH_HI, ST_LATCH_LO, ST_CLK_LO, ST_CLK_HI
  } seq_state_e;

  typedef struct packed {
    logic clearShift;
    logic sampleBit;
    logic commitWords;
  } dp_strobe_t;
endpackage

// File: rtl/padpoll_ctrl.sv
module padpoll_ctrl
  import padpoll_pkg::*;
#(
  parameter int PHASE_CYC = 120
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vbStart,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrBit,
  output logic              enable,
  output logic              busy,
  output logic              padLatch,
  output logic              pad1Clk,
  output logic              pad2Clk,
  output dp_strobe_t        strobe
);
  localparam int PH_W = $clog2(PHASE_CYC + 1);
  localparam int BC_W = $clog2(LINE_BITS);

  seq_state_e      state;
  logic [PH_W-1:0] phaseCnt;
  logic [BC_W-1:0] bitCnt;
  logic            manLatch;
  logic            man1Pulse;
  logic            man2Pulse;
  logic            lastPhase;
  logic            lastBit;
  logic            startReq;

  assign busy      = (state != ST_IDLE);
  assign lastPhase = (phaseCnt == PH_W'(PHASE_CYC - 1));
  assign lastBit   = (bitCnt == BC_W'(LINE_BITS - 1));
  assign startReq  = vbStart && enable && !busy;

  assign strobe.clearShift  = startReq;
  assign strobe.sampleBit   = (state == ST_CLK_LO) && lastPhase;
  assign strobe.commitWords = (state == ST_CLK_HI) && lastPhase && lastBit;

  assign padLatch = busy ? (state == ST_LATCH_HI) : manLatch;
  assign pad1Clk  = busy ? (state != ST_CLK_LO) : !man1Pulse;
  assign pad2Clk  = busy ? (state != ST_CLK_LO) : !man2Pulse;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      phaseCnt  <= '0;
      bitCnt    <= '0;
      enable    <= 1'b0;
      manLatch  <= 1'b0;
      man1Pulse <= 1'b0;
      man2Pulse <= 1'b0;
    end else begin
      if (wrEn && addr == REG_CTRL) enable <= wrBit;
      if (wrEn && addr == REG_PORT1 && !busy) manLatch <= wrBit;
      man1Pulse <= rdEn && (addr == REG_PORT1) && !busy;
      man2Pulse <= rdEn && (addr == REG_PORT2) && !busy;

      if (state == ST_IDLE) begin
        phaseCnt <= '0;
        bitCnt   <= '0;
        if (startReq) state <= ST_LATCH_HI;
      end else if (!lastPhase) begin
        phaseCnt <= phaseCnt + 1'b1;
      end else begin
        phaseCnt <= '0;
        unique case (state)
          ST_LATCH_HI: state <= ST_LATCH_LO;
          ST_LATCH_LO: state <= ST_CLK_LO;
          ST_CLK_LO:   state <= ST_CLK_HI;
          ST_CLK_HI: begin
            if (lastBit) begin
              state <= ST_IDLE;
            end else begin
              bitCnt <= bitCnt + 1'b1;
              state  <= ST_CLK_LO;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/padpoll_dp.sv
module padpoll_dp
  import padpoll_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  dp_strobe_t                      strobe,
  input  logic [1:0]                      pad1Data,
  input  logic [1:0]                      pad2Data,
  input  logic [ADDR_W-1:0]               addr,
  input  logic                            enable,
  input  logic                            busy,
  output logic [DATA_W-1:0]               rdData,
  output logic [NUM_WORDS*LINE_BITS-1:0]  resFlat
);
  logic [NUM_WORDS-1:0] lineBits;
  logic [LINE_BITS-1:0] resWord [NUM_WORDS];

  assign lineBits = {pad2Data[1], pad1Data[1], pad2Data[0], pad1Data[0]};

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
    logic [LINE_BITS-1:0] shiftReg;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        shiftReg   <= '0;
        resWord[k] <= '0;
      end else begin
        if (strobe.clearShift)
          shiftReg <= '0;
        else if (strobe.sampleBit)
          shiftReg <= {shiftReg[LINE_BITS-2:0], lineBits[k]};
        if (strobe.commitWords)
          resWord[k] <= shiftReg;
      end
    end
    assign resFlat[k*LINE_BITS +: LINE_BITS] = resWord[k];
  end

  always_comb begin
    rdData = '0;
    if (addr[ADDR_W-1]) begin
      rdData = addr[0] ? resWord[addr[2:1]][15:8] : resWord[addr[2:1]][7:0];
    end else begin
      unique case (addr)
        REG_CTRL:   rdData[0] = enable;
        REG_STATUS: rdData[0] = busy;
        REG_PORT1:  rdData[1:0] = pad1Data;
        REG_PORT2:  rdData[1:0] = pad2Data;
        default:    rdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/padpoll_top.sv
module padpoll_top
  import padpoll_pkg::*;
#(
  parameter int PHASE_CYC = 120
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        vbStart,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [3:0]  addr,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData,
  output logic        padLatch,
  output logic        pad1Clk,
  output logic        pad2Clk,
  input  logic [1:0]  pad1Data,
  input  logic [1:0]  pad2Data
);
  dp_strobe_t                     strobe;
  logic                           enable;
  logic                           busy;
  logic [NUM_WORDS*LINE_BITS-1:0] resFlat;

  padpoll_ctrl #(.PHASE_CYC(PHASE_CYC)) ctrl_i (
    .clk(clk), .rstN(rstN), .vbStart(vbStart), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrBit(wrData[0]), .enable(enable), .busy(busy),
    .padLatch(padLatch), .pad1Clk(pad1Clk), .pad2Clk(pad2Clk), .strobe(strobe)
  );

  padpoll_dp dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pad1Data(pad1Data),
    .pad2Data(pad2Data), .addr(addr), .enable(enable), .busy(busy),
    .rdData(rdData), .resFlat(resFlat)
  );
endmodule

// File: rtl/padpoll_chk.sv
module padpoll_chk #(
  parameter int PHASE_CYC = 120
) (
  input logic        clk,
  input logic        rstN,
  input logic        vbStart,
  input logic        enable,
  input logic        busy,
  input logic        padLatch,
  input logic        pad1Clk,
  input logic        pad2Clk,
  input logic [63:0] resFlat
);
  int busyCnt;

  always_ff @(posedge clk) begin
    if (!rstN) busyCnt <= 0;
    else if (busy) busyCnt <= busyCnt + 1;
    else busyCnt <= 0;
  end

  assert_start_cause_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(vbStart && enable));

  assert_clock_pair_R3: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (pad1Clk == pad2Clk));

  assert_latch_clock_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && padLatch) |-> pad1Clk);

  assert_busy_length_R3: assert property (@(posedge clk) disable iff (!rstN)
    busyCnt <= 34 * PHASE_CYC);

  assert_hold_results_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busy ? $stable(resFlat) : 1'b1));

  assert_idle_clocks_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy)) |-> !(pad1Clk == 1'b0 && pad2Clk == 1'b0));
endmodule

bind padpoll_top padpoll_chk #(.PHASE_CYC(PHASE_CYC)) chk_i (
  .clk(clk), .rstN(rstN), .vbStart(vbStart), .enable(enable), .busy(busy),
  .padLatch(padLatch), .pad1Clk(pad1Clk), .pad2Clk(pad2Clk), .resFlat(resFlat)
);

// File: tb/padpoll_tb.sv
`timescale 1ns/1ps
module padpoll_top_tb_top;
  localparam int P = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       vbStart = 1'b0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic       padLatch, pad1Clk, pad2Clk;
  logic [1:0] pad1Data, pad2Data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [15:0] padWord [4];
  logic [15:0] sh [4];
  logic [15:0] prevWord [4];
  int clk1Falls = 0, clk2Falls = 0, latchRises = 0, viol = 0;
  bit inFrame = 1'b0;

  always #4 clk = ~clk;

  padpoll_top #(.PHASE_CYC(P)) dut_i (
    .clk(clk), .rstN(rstN), .vbStart(vbStart), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .padLatch(padLatch),
    .pad1Clk(pad1Clk), .pad2Clk(pad2Clk), .pad1Data(pad1Data), .pad2Data(pad2Data)
  );

  // controller model: loads on latch, shifts on clock returning high
  always @(posedge padLatch or posedge pad1Clk) begin
    if (padLatch) begin sh[0] <= padWord[0]; sh[2] <= padWord[2]; end
    else begin sh[0] <= {sh[0][14:0], 1'b1}; sh[2] <= {sh[2][14:0], 1'b1}; end
  end
  always @(posedge padLatch or posedge pad2Clk) begin
    if (padLatch) begin sh[1] <= padWord[1]; sh[3] <= padWord[3]; end
    else begin sh[1] <= {sh[1][14:0], 1'b1}; sh[3] <= {sh[3][14:0], 1'b1}; end
  end
  assign pad1Data = {sh[2][15], sh[0][15]};
  assign pad2Data = {sh[3][15], sh[1][15]};

  always @(negedge pad1Clk) clk1Falls++;
  always @(negedge pad2Clk) clk2Falls++;
  always @(posedge padLatch) latchRises++;
  always @(negedge clk) if (inFrame && ((padLatch && !pad1Clk) || (pad1Clk != pad2Clk))) viol++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    addr = a; rdEn = 1'b1;
    #1 v = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic checkResults(input string req, input logic [15:0] exp [4]);
    logic [7:0] lo, hi;
    for (int k = 0; k < 4; k++) begin
      rd(4'(8 + 2*k), lo);
      rd(4'(9 + 2*k), hi);
      chk(req, {hi, lo}, exp[k]);
    end
  endtask

  task automatic runFrame(input logic [15:0] w [4], input bit meddle);
    logic [7:0] v;
    int n;
    int pre;
    for (int k = 0; k < 4; k++) padWord[k] = w[k];
    clk1Falls = 0; clk2Falls = 0; latchRises = 0; viol = 0;
    inFrame = 1'b1;
    vbStart = 1'b1;
    @(negedge clk);
    vbStart = 1'b0;
    pre = 0;
    if (meddle) begin
      wr(4'd2, 8'd1);          // R7: ignored while busy
      rd(4'd2, v);             // R8: no clock pulse while busy
      rd(4'd8, v);             // R9: old value during the read
      chk("R9 old result during read", v, prevWord[0][7:0]);
      vbStart = 1'b1;          // R2: no restart while busy
      @(negedge clk);
      vbStart = 1'b0;
      pre = 4;
    end
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      rd(4'd1, v);
      if (!v[0]) break;
      n++;
    end
    inFrame = 1'b0;
    chk("R3 busy length", n, 34*P - pre);
    chk("R3 port1 clock pulses", clk1Falls, 16);
    chk("R3 port2 clock pulses", clk2Falls, 16);
    chk("R3 latch pulses", latchRises, 1);
    chk("R3 latch/clock overlap", viol, 0);
    if (meddle) chk("R7 latch after busy write", padLatch, 0);
    checkResults("R4 R5 result word", w);
    for (int k = 0; k < 4; k++) prevWord[k] = w[k];
  endtask

  initial begin
    logic [7:0] v;
    logic [15:0] w [4];
    for (int k = 0; k < 4; k++) begin padWord[k] = 16'h0; prevWord[k] = 16'h0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'd0, v); chk("R1 enable after reset", v, 8'h00);
    rd(4'd1, v); chk("R1 busy after reset", v, 8'h00);
    chk("R1 latch low", padLatch, 0);
    chk("R1 clocks high", {pad1Clk, pad2Clk}, 2'b11);
    for (int a = 8; a < 16; a++) begin
      rd(4'(a), v); chk("R1 result byte after reset", v, 8'h00);
    end

    // R2 no start while disabled
    latchRises = 0;
    vbStart = 1'b1; @(negedge clk); vbStart = 1'b0;
    rd(4'd1, v); chk("R2 no start when disabled", v, 8'h00);
    chk("R2 no latch when disabled", latchRises, 0);

    // R6 enable register
    wr(4'd0, 8'hFF);
    rd(4'd0, v); chk("R6 enable readback", v, 8'h01);

    // R4 sweeps: walking bits then mixed patterns
    for (int i = 0; i < 12; i++) begin
      for (int k = 0; k < 4; k++) begin
        if (i < 4) w[k] = 16'h1 << ((i*4 + k) % 16);
        else if (i < 8) w[k] = 16'h8000 >> ((i*4 + k) % 16);
        else if (i == 8) w[k] = 16'hFFFF;
        else if (i == 9) w[k] = 16'h0000;
        else w[k] = 16'(16'hA5C3 * (i + 1)) ^ 16'(k * 16'h1111);
      end
      runFrame(w, 1'b0);
    end

    // R2 R7 R8 R9 interference during a read
    w[0] = 16'h8001; w[1] = 16'h4002; w[2] = 16'h2004; w[3] = 16'h1008;
    runFrame(w, 1'b1);

    // R2 disabled again: results hold
    wr(4'd0, 8'h00);
    latchRises = 0;
    vbStart = 1'b1; @(negedge clk); vbStart = 1'b0;
    rd(4'd1, v); chk("R2 disabled start ignored", v, 8'h00);
    chk("R2 disabled no latch", latchRises, 0);
    checkResults("R9 results hold", prevWord);

    // R7 R8 manual mode, port 1
    padWord[0] = 16'hC35A; padWord[2] = 16'h0FF1;
    wr(4'd2, 8'h01);
    chk("R7 manual latch high", padLatch, 1);
    wr(4'd2, 8'h00);
    chk("R7 manual latch low", padLatch, 0);
    for (int b = 15; b >= 0; b--) begin
      rd(4'd2, v);
      chk("R8 manual port1 read", v, {6'b0, padWord[2][b], padWord[0][b]});
      @(negedge clk);
    end
    rd(4'd2, v); chk("R8 manual port1 past end", v, 8'h03);
    @(negedge clk);

    // R8 port 2
    padWord[1] = 16'hA000; padWord[3] = 16'h6000;
    wr(4'd2, 8'h01); wr(4'd2, 8'h00);
    for (int b = 15; b >= 12; b--) begin
      rd(4'd3, v);
      chk("R8 manual port2 read", v, {6'b0, padWord[3][b], padWord[1][b]});
      @(negedge clk);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule